// File: doc/BRIEF.md
# Oversampling Serial Receiver with Three-Sample Voting

This block receives asynchronous serial frames. The frame is a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and a high stop bit. The line is sampled once on each pulse of an external sample enable. That enable runs at sixteen times the bit rate in normal mode and eight times the bit rate in fast mode. Each bit is settled by taking the majority of three samples near its middle. A short low glitch on an idle line is therefore thrown away as noise and does not start a frame. A single corrupted sample inside a bit also has no effect.

The serial input is resynchronised to the block clock by two flip-flops. The bit-position counter realigns on every accepted start bit. When the stop bit has been voted, one strobe presents the assembled word together with a frame-error flag and a parity-error flag. The receiver can then detect a new start bit before a full-length stop bit has elapsed.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset `rx_valid`, `rx_data`, `frm_err` and `par_err` are all 0 and the receiver is idle.
- R2: `rxd` passes through two clock flip-flops. On a sample pulse, a high sample followed by a low sample starts a frame, and that first low sample is counted as sample 1 of the start bit.
- R3: The start bit is voted on samples 8, 9 and 10 in normal mode (`fast_mode`=0) and on samples 4, 5 and 6 in fast mode. If two or more of these samples are high, the start is dropped, no strobe is produced, and the receiver waits for the next high-to-low change.
- R4: A bit lasts 16 sample pulses in normal mode and 8 in fast mode. Every data, parity and stop bit takes the majority value of the same three sample positions used for the start bit, so one flipped sample inside a bit does not change the result.
- R5: `len_sel` sets the data length: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The first data bit received lands in `rx_data[0]`, and bits above the length read 0.
- R6: When `par_en`=1, one parity bit follows the data. `par_odd`=0 requires an even number of ones across the data and parity bits, and `par_odd`=1 requires an odd number. A mismatch sets `par_err`. When `par_en`=0, `par_err` reads 0.
- R7: Only the first stop bit is sampled. If its voted value is 0, `frm_err` is 1 for that frame.
- R8: `rx_valid` is high for exactly one clock after each stop-bit vote. `rx_data`, `frm_err` and `par_err` change only together with that strobe and hold their values until the next one.
- R9: In normal mode a new start bit is detected if its first low sample is the one right after stop sample 10. In fast mode the first low sample may come no earlier than stop sample 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | One-clock sample pulse at 16x (normal) or 8x (fast) the bit rate |
| rxd | input | 1 | Serial line, idle high |
| fast_mode | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| len_sel | input | 2 | Data length code, number of bits = code + 5 |
| par_en | input | 1 | 1 expects a parity bit after the data |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rx_data | output | 8 | Received word, right-aligned |
| rx_valid | output | 1 | One-clock strobe for a completed frame |
| frm_err | output | 1 | Stop bit was voted low |
| par_err | output | 1 | Parity check failed |

## Verification
The assertions assume that `smp_en` is a single-clock pulse with at least one idle clock between pulses. They also assume that `fast_mode`, `len_sel`, `par_en` and `par_odd` change only while no frame is in progress. The bench meets both assumptions: it generates one enable pulse every fourth clock, and it changes the configuration only during an idle-high gap between frames. Serial levels are held for whole multiples of four clocks, so every sample position inside a bit, including deliberate glitches and shortened stop bits, falls on a known sample pulse.

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int DW  = 8,
  parameter int OSN = 16,
  parameter int OSF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          rxd,
  input  logic          fast_mode,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_odd,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          frm_err,
  output logic          par_err
);
  localparam int CW = $clog2(OSN + 1);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] N_END = CW'(OSN);
  localparam logic [CW-1:0] F_END = CW'(OSF);
  localparam logic [CW-1:0] N_MID = CW'(OSN / 2);
  localparam logic [CW-1:0] F_MID = CW'(OSF / 2);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_TAIL} st_t;

  st_t           st;
  logic          sy1, sy2, line_q;
  logic [CW-1:0] cnt;
  logic [1:0]    vq;
  logic [BW-1:0] bidx;
  logic [DW-1:0] sh;
  logic          acc, perr_q;

  logic [CW-1:0] nxt, lo, hi, lim;
  logic [1:0]    pad;
  logic [BW-1:0] last_idx;
  logic          in_win, last_v, bit_end, vote, fall;

  assign nxt      = cnt + CW'(1);
  assign lo       = fast_mode ? F_MID : N_MID;
  assign hi       = lo + CW'(2);
  assign lim      = fast_mode ? F_END : N_END;
  assign in_win   = (nxt >= lo) && (nxt <= hi);
  assign last_v   = (nxt == hi);
  assign bit_end  = (nxt == lim);
  assign vote     = (vq[1] & vq[0]) | (vq[1] & sy2) | (vq[0] & sy2);
  assign fall     = line_q & ~sy2;
  assign pad      = 2'd3 - len_sel;
  assign last_idx = BW'(DW - 1) - BW'(pad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b1; sy2 <= 1'b1; line_q <= 1'b1;
      st <= S_IDLE; cnt <= '0; vq <= '0; bidx <= '0;
      sh <= '0; acc <= 1'b0; perr_q <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; frm_err <= 1'b0; par_err <= 1'b0;
    end else begin
      sy1 <= rxd;
      sy2 <= sy1;
      rx_valid <= 1'b0;
      if (smp_en) begin
        line_q <= sy2;
        if (in_win) vq <= {vq[0], sy2};
        cnt <= bit_end ? '0 : nxt;
        unique case (st)
          S_IDLE: begin
            cnt <= nxt;
            if (fall) begin
              st <= S_START; cnt <= CW'(1);
              bidx <= '0; sh <= '0; acc <= 1'b0; perr_q <= 1'b0;
            end
          end
          S_START: begin
            if (last_v && vote) st <= S_IDLE;
            else if (bit_end) st <= S_DATA;
          end
          S_DATA: begin
            if (last_v) begin
              sh  <= {vote, sh[DW-1:1]};
              acc <= acc ^ vote;
            end
            if (bit_end) begin
              bidx <= bidx + BW'(1);
              if (bidx == last_idx) st <= par_en ? S_PAR : S_STOP;
            end
          end
          S_PAR: begin
            if (last_v) perr_q <= acc ^ vote ^ par_odd;
            if (bit_end) st <= S_STOP;
          end
          S_STOP: begin
            if (last_v) begin
              rx_valid <= 1'b1;
              rx_data  <= sh >> pad;
              frm_err  <= ~vote;
              par_err  <= par_en & perr_q;
              st       <= fast_mode ? S_TAIL : S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r8_flags_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(frm_err) || !$stable(par_err) || !$stable(rx_data)) |-> rx_valid);
  a_r8_strobe_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(st) == S_STOP);
  a_r2_start_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && smp_en && line_q && !sy2) |=> (st == S_START && cnt == CW'(1)));
  a_r4_hold_between_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(st) && $stable(cnt)));
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (cnt < N_END));
  a_r9_tail_fast_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAIL) |-> fast_mode);
endmodule

// File: tb/sim_uart_vote_rx.sv
module sim_uart_vote_rx;
  logic clk = 1'b0, rst_n = 1'b0, smp_en = 1'b0, rxd = 1'b1;
  logic fast_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic [7:0] rx_data;
  logic rx_valid, frm_err, par_err;

  uart_vote_rx u0 (.clk(clk), .rst_n(rst_n), .smp_en(smp_en), .rxd(rxd),
    .fast_mode(fast_mode), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .rx_data(rx_data), .rx_valid(rx_valid), .frm_err(frm_err), .par_err(par_err));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m1 = 1, m2 = 1, mline = 1;
  int m_st = 0, m_cnt = 0, ones = 0;
  bit pbit = 0;
  bit qbits[$];
  bit e_valid = 0, e_fe = 0, e_pe = 0;
  logic [7:0] e_data = 0;

  always @(posedge clk) begin
    bit s, maj, x;
    int ns, lo, hi, n;
    if (!rst_n) begin
      m1 = 1; m2 = 1; mline = 1; m_st = 0; m_cnt = 0;
      e_valid = 0; e_fe = 0; e_pe = 0; e_data = 0; qbits.delete();
    end else begin
      s = m2; m2 = m1; m1 = rxd; e_valid = 0;
      if (smp_en) begin
        ns = fast_mode ? 8 : 16; lo = ns / 2; hi = lo + 2;
        n = m_cnt + 1;
        if (n == lo) ones = s; else if (n > lo && n <= hi) ones += s;
        maj = (ones >= 2);
        if (m_st == 0) begin
          m_cnt = n;
          if (mline && !s) begin m_st = 1; m_cnt = 1; qbits.delete(); end
        end else begin
          m_cnt = (n == ns) ? 0 : n;
          case (m_st)
            1: if (n == hi && maj) m_st = 0; else if (n == ns) m_st = 2;
            2: begin
              if (n == hi) qbits.push_back(maj);
              if (n == ns && qbits.size() == len_sel + 5) m_st = par_en ? 3 : 4;
            end
            3: begin if (n == hi) pbit = maj; if (n == ns) m_st = 4; end
            4: if (n == hi) begin
              e_valid = 1; e_data = 0; x = pbit ^ par_odd;
              foreach (qbits[i]) begin e_data[i] = qbits[i]; x ^= qbits[i]; end
              e_fe = !maj; e_pe = par_en && x;
              m_st = fast_mode ? 5 : 0;
            end
            default: m_st = 0;
          endcase
        end
        mline = s;
      end
    end
  end

  logic [7:0] rxq[$];
  bit feq[$], peq[$];

  always @(negedge clk) if (rst_n && !done) begin
    chk({cur_req, " strobe"}, rx_valid, e_valid);
    chk({cur_req, " data"}, rx_data, e_data);
    chk({cur_req, " ferr"}, frm_err, e_fe);
    chk({cur_req, " perr"}, par_err, e_pe);
    if (rx_valid) begin rxq.push_back(rx_data); feq.push_back(frm_err); peq.push_back(par_err); end
  end

  initial forever begin
    repeat (3) @(negedge clk);
    smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
  end

  task automatic hold(bit v, int n);
    rxd = v;
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, int stop_v, int stop_len, int glitch, bit flip_par);
    int ns, nb;
    bit p;
    ns = fast_mode ? 8 : 16; nb = len_sel + 5; p = par_odd ^ flip_par;
    hold(0, ns);
    for (int i = 0; i < nb; i++) begin
      p ^= d[i];
      if (glitch == i) begin
        hold(d[i], ns / 2); hold(!d[i], 1); hold(d[i], ns / 2 - 1);
      end else hold(d[i], ns);
    end
    if (par_en) hold(p, ns);
    hold(stop_v[0], stop_len < 0 ? ns : stop_len);
  endtask

  task automatic gap(); hold(1, 40); endtask

  task automatic clr(); rxq.delete(); feq.delete(); peq.delete(); endtask

  task automatic expect1(string req, logic [7:0] d, bit fe, bit pe);
    chk({req, " count"}, rxq.size(), 1);
    if (rxq.size() == 1) begin
      chk({req, " word"}, rxq[0], d);
      chk({req, " frame flag"}, feq[0], fe);
      chk({req, " parity flag"}, peq[0], pe);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", rx_valid, 0); chk("R1 data", rx_data, 0);
    chk("R1 ferr", frm_err, 0);   chk("R1 perr", par_err, 0);
    rst_n = 1'b1;
    gap();
    cur_req = "R2"; clr(); send(8'hA5, 1, -1, -1, 0); gap(); expect1("R2 R5 len8", 8'hA5, 0, 0);
    cur_req = "R5"; len_sel = 0; gap(); clr(); send(8'hF3, 1, -1, -1, 0); gap(); expect1("R5 len5", 8'h13, 0, 0);
    len_sel = 1; gap(); clr(); send(8'h2D, 1, -1, -1, 0); gap(); expect1("R5 len6", 8'h2D, 0, 0);
    len_sel = 2; gap(); clr(); send(8'hC1, 1, -1, -1, 0); gap(); expect1("R5 len7", 8'h41, 0, 0);
    cur_req = "R6"; len_sel = 3; par_en = 1; gap();
    clr(); send(8'h37, 1, -1, -1, 0); gap(); expect1("R6 even ok", 8'h37, 0, 0);
    par_odd = 1; gap();
    clr(); send(8'h37, 1, -1, -1, 0); gap(); expect1("R6 odd ok", 8'h37, 0, 0);
    clr(); send(8'h5A, 1, -1, -1, 1); gap(); expect1("R6 odd bad", 8'h5A, 0, 1);
    par_odd = 0; gap();
    clr(); send(8'h01, 1, -1, -1, 1); gap(); expect1("R6 even bad", 8'h01, 0, 1);
    par_en = 0; gap();
    cur_req = "R7"; clr(); send(8'h66, 0, -1, -1, 0); gap(); expect1("R7 low stop", 8'h66, 1, 0);
    cur_req = "R3"; clr(); hold(0, 3); gap(); hold(0, 7); gap();
    chk("R3 spike dropped", rxq.size(), 0);
    clr(); send(8'h9C, 1, -1, -1, 0); gap(); expect1("R3 after spike", 8'h9C, 0, 0);
    cur_req = "R4"; clr(); send(8'hB4, 1, -1, 2, 0); gap(); expect1("R4 glitch normal", 8'hB4, 0, 0);
    cur_req = "R9"; clr(); send(8'h3C, 1, 10, -1, 0); send(8'hC3, 1, -1, -1, 0); gap();
    chk("R9 normal pair", rxq.size(), 2);
    if (rxq.size() == 2) begin chk("R9 first", rxq[0], 8'h3C); chk("R9 second", rxq[1], 8'hC3); chk("R9 no ferr", feq[1], 0); end
    fast_mode = 1; gap();
    cur_req = "R4"; clr(); send(8'h4B, 1, -1, 5, 0); gap(); expect1("R4 glitch fast", 8'h4B, 0, 0);
    cur_req = "R3"; clr(); hold(0, 3); gap(); chk("R3 fast spike dropped", rxq.size(), 0);
    cur_req = "R9"; clr(); send(8'h81, 1, 7, -1, 0); send(8'h7E, 1, -1, -1, 0); gap();
    chk("R9 fast pair", rxq.size(), 2);
    if (rxq.size() == 2) begin chk("R9 fast first", rxq[0], 8'h81); chk("R9 fast second", rxq[1], 8'h7E); end
    cur_req = "R6"; par_en = 1; par_odd = 1; len_sel = 1; gap();
    clr(); send(8'h15, 1, -1, -1, 1); gap(); expect1("R6 fast bad", 8'h15, 0, 1);
    cur_req = "R8"; par_en = 0; len_sel = 3; gap();
    clr(); send(8'hE7, 0, -1, -1, 0); gap(); expect1("R8 fast strobe", 8'hE7, 1, 0);
    gap(); chk("R8 held data", rx_data, 8'hE7); chk("R8 held ferr", frm_err, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1; n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule